// File: doc/BRIEF.md
# Buffered Serial Target Transceiver

This block is the target side of a clocked serial link. An external controller supplies the serial clock, and the block uses no other timing source for shifting. The serial clock rests high. On every falling edge the block drives the next transmit bit, and on every rising edge it captures the input bit. Words are eight bits long by default and travel most significant bit first on both lines. The serial clock is brought into the system clock domain through a short synchroniser, and both edges are detected there. The system clock must therefore run several times faster than the serial clock.

On the bus side, a one-cycle write strobe loads a transmit holding register and a one-cycle read strobe takes the received word. The holding register hands its byte to the shifter on the first falling edge of a word and pulses a ready output, so software can load the next byte while the current one is still shifting. When the controller keeps clocking without a pause, the next word follows at once. If nothing new was written, the byte last loaded is sent again. A busy flag tells software whether a transfer it asked for is still outstanding. An overrun flag reports a received word that was replaced before it was read.

Top module: `spi_tgt_xcvr`

## Requirements
- R1: After reset, `sdo_o`, `busy_o`, `tx_ready_o`, `rx_done_o`, `rx_valid_o` and `overrun_o` are all 0, and the holding register contains 0.
- R2: On the first falling serial edge of a word, the most significant bit of the holding register is driven on `sdo_o`. Each later falling edge of that word drives the next lower bit, so bit 7 goes first.
- R3: A write strobe sets `busy_o` on the next clock cycle.
- R4: `sdi_i` is captured on each rising serial edge, most significant bit first. After the eighth rising edge of a word, `rd_data_o` holds the word, `rx_valid_o` is 1, and `rx_done_o` is high for exactly one cycle.
- R5: `tx_ready_o` pulses for one cycle when a word starts while the holding register contains unsent data. No pulse occurs when the holding register has no unsent data.
- R6: `busy_o` falls in the cycle after a `rx_done_o` pulse if no unsent data remains. It stays high if a write arrived during the word.
- R7: While the serial clock runs without a gap, each new word starts on the next falling edge, and no idle bit is inserted between words.
- R8: A word that starts with no new write repeats the byte last written.
- R9: A word that completes while `rx_valid_o` is still 1 and unread sets `overrun_o` in the same cycle as `rx_done_o`. The newer word replaces the one in `rd_data_o`.
- R10: A read strobe clears `rx_valid_o` and `overrun_o` on the next cycle, unless a word completes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the controller, idle high |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Transmit byte |
| rd_en_i | input | 1 | Read strobe for the receive register |
| rd_data_o | output | DATA_W | Received word |
| tx_ready_o | output | 1 | Holding register handed off, one-cycle pulse |
| rx_done_o | output | 1 | Word received, one-cycle pulse |
| busy_o | output | 1 | Requested transfer still outstanding |
| rx_valid_o | output | 1 | Unread received word present |
| overrun_o | output | 1 | Unread word was overwritten |

## Verification
The assertions assume two things about the serial clock. Each of its levels lasts longer than the synchroniser delay, so edge pulses never touch one another. It also never toggles in the same cycle as a completion pulse, so a strobe and an internal update never race. `sdi_i` is assumed to stay steady around each rising edge. The bench holds each serial clock phase for six system clocks and changes data only while the serial clock is low. It places writes and reads between edges, so each stimulus stays inside these limits.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
    parameter int unsigned SPI_WORD_W_DEF = 8;
    parameter int unsigned SPI_SYNC_DEF   = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;
endpackage

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge
    import spi_tgt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SPI_SYNC_DEF
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      sck_i,
    output sck_edge_t edge_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        synced;

    assign synced = st_q.chain[SYNC_STAGES-1];

    always_comb begin
        st_d = st_q;
        if (SYNC_STAGES > 1) begin
            st_d.chain = {st_q.chain[SYNC_STAGES-2:0], sck_i};
        end else begin
            st_d.chain[0] = sck_i;
        end
        st_d.last = synced;
        edge_o.rise = synced & ~st_q.last;
        edge_o.fall = ~synced & st_q.last;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{chain: '1, last: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_tgt_tx.sv
module spi_tgt_tx #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fall_i,
    input  logic              word_done_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              sdo_o,
    output logic              tx_ready_o,
    output logic              busy_o
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              pending;
        logic [DATA_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic              dout;
        logic              ready;
        logic              busy;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;

        if (fall_i) begin
            if (st_q.cnt == '0) begin
                st_d.dout    = st_q.hold[DATA_W-1];
                st_d.shift   = st_q.hold << 1;
                st_d.pending = 1'b0;
                st_d.ready   = st_q.pending;
            end else begin
                st_d.dout  = st_q.shift[DATA_W-1];
                st_d.shift = st_q.shift << 1;
            end
            st_d.cnt = (st_q.cnt == LAST_BIT) ? '0 : st_q.cnt + 1'b1;
        end

        if (word_done_i && !st_q.pending) begin
            st_d.busy = 1'b0;
        end

        if (wr_en_i) begin
            st_d.hold    = wr_data_i;
            st_d.pending = 1'b1;
            st_d.busy    = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o      = st_q.dout;
    assign tx_ready_o = st_q.ready;
    assign busy_o     = st_q.busy;
endmodule

// File: rtl/spi_tgt_rx.sv
module spi_tgt_rx #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rise_i,
    input  logic              sdi_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rx_done_o,
    output logic              rx_valid_o,
    output logic              overrun_o
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              valid;
        logic              ovr;
    } rx_state_t;

    rx_state_t         st_d, st_q;
    logic [DATA_W-1:0] next_word;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        next_word = {st_q.shift[DATA_W-2:0], sdi_i};

        if (rd_en_i) begin
            st_d.valid = 1'b0;
            st_d.ovr   = 1'b0;
        end

        if (rise_i) begin
            st_d.shift = next_word;
            if (st_q.cnt == LAST_BIT) begin
                st_d.cnt   = '0;
                st_d.data  = next_word;
                st_d.done  = 1'b1;
                st_d.valid = 1'b1;
                st_d.ovr   = st_d.ovr | (st_q.valid & ~rd_en_i);
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o  = st_q.data;
    assign rx_done_o  = st_q.done;
    assign rx_valid_o = st_q.valid;
    assign overrun_o  = st_q.ovr;
endmodule

// File: rtl/spi_tgt_xcvr.sv
module spi_tgt_xcvr
    import spi_tgt_pkg::*;
#(
    parameter int unsigned DATA_W      = SPI_WORD_W_DEF,
    parameter int unsigned SYNC_STAGES = SPI_SYNC_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              tx_ready_o,
    output logic              rx_done_o,
    output logic              busy_o,
    output logic              rx_valid_o,
    output logic              overrun_o
);
    sck_edge_t sck_edge;
    logic      word_done;

    spi_tgt_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sck_i  (sck_i),
        .edge_o (sck_edge)
    );

    spi_tgt_tx #(.DATA_W(DATA_W)) tx_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fall_i      (sck_edge.fall),
        .word_done_i (word_done),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .sdo_o       (sdo_o),
        .tx_ready_o  (tx_ready_o),
        .busy_o      (busy_o)
    );

    spi_tgt_rx #(.DATA_W(DATA_W)) rx_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rise_i     (sck_edge.rise),
        .sdi_i      (sdi_i),
        .rd_en_i    (rd_en_i),
        .rd_data_o  (rd_data_o),
        .rx_done_o  (word_done),
        .rx_valid_o (rx_valid_o),
        .overrun_o  (overrun_o)
    );

    assign rx_done_o = word_done;
endmodule

// File: rtl/spi_tgt_xcvr_chk.sv
module spi_tgt_xcvr_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic wr_en_i,
    input logic rd_en_i,
    input logic tx_ready_o,
    input logic rx_done_o,
    input logic busy_o,
    input logic rx_valid_o,
    input logic overrun_o
);
    assert_write_sets_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> busy_o);

    assert_done_marks_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_done_o |-> rx_valid_o);

    assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_done_o |=> !rx_done_o);

    assert_ready_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_ready_o |=> !tx_ready_o);

    assert_busy_falls_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> $past(rx_done_o));

    assert_overrun_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(overrun_o) |-> rx_done_o);

    assert_read_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> (rx_done_o || (!rx_valid_o && !overrun_o)));
endmodule

bind spi_tgt_xcvr spi_tgt_xcvr_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .tx_ready_o (tx_ready_o),
    .rx_done_o  (rx_done_o),
    .busy_o     (busy_o),
    .rx_valid_o (rx_valid_o),
    .overrun_o  (overrun_o)
);

// File: tb/spi_tgt_xcvr_tb_top.sv
module spi_tgt_xcvr_tb_top;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tx_ready, rx_done, busy, rx_valid, overrun;

    int checks = 0;
    int fails = 0;
    int ready_cnt = 0;
    logic [7:0] rx_q[$];

    always #10 clk = ~clk;

    spi_tgt_xcvr dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .tx_ready_o(tx_ready), .rx_done_o(rx_done), .busy_o(busy),
        .rx_valid_o(rx_valid), .overrun_o(overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares each completed word against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && tx_ready) ready_cnt++;
        if (rst_n && rx_done) begin
            if (rx_q.size() == 0) begin
                check(1'b0, "R4 unexpected word", int'(rd_data), 0);
            end else begin
                logic [7:0] e;
                e = rx_q.pop_front();
                check(rd_data == e && rx_valid, "R4 received word", int'(rd_data), int'(e));
            end
        end
    end

    task automatic bus_write(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(output logic [7:0] b);
        rd_en = 1'b1; b = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] m, input logic [7:0] exp_tx,
                        input bit do_wr, input logic [7:0] wb, input string req);
        logic [7:0] got;
        rx_q.push_back(m);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            sck = 1'b0; sdi = m[i];
            if (do_wr && i == 4) begin
                bus_write(wb);
                repeat (HALF - 1) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            got[i] = sdo;
            sck = 1'b1;
            repeat (HALF - 1) @(negedge clk);
        end
        check(got == exp_tx, req, int'(got), int'(exp_tx));
    endtask

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && sdo == 0 && tx_ready == 0 && rx_done == 0, "R1 outputs", int'(busy), 0);
        check(rx_valid == 0 && overrun == 0, "R1 flags", int'(rx_valid), 0);

        bus_write(8'hA5);
        check(busy == 1, "R3 busy after write", int'(busy), 1);

        xfer(8'h3C, 8'hA5, 1'b0, 8'h00, "R2 msb-first transmit");
        check(ready_cnt == 1, "R5 one handoff pulse", ready_cnt, 1);
        check(busy == 0, "R6 busy clears with no pending data", int'(busy), 0);
        bus_read(b);
        check(b == 8'h3C, "R4 read value", int'(b), 8'h3C);
        @(negedge clk);
        check(rx_valid == 0, "R10 valid cleared", int'(rx_valid), 0);

        bus_write(8'h96);
        xfer(8'h11, 8'h96, 1'b1, 8'h5A, "R2 second word");
        check(busy == 1, "R6 busy held by pending write", int'(busy), 1);
        xfer(8'h22, 8'h5A, 1'b0, 8'h00, "R7 back-to-back word");
        check(overrun == 1, "R9 overrun set", int'(overrun), 1);
        check(rd_data == 8'h22, "R9 newer word kept", int'(rd_data), 8'h22);
        check(busy == 0, "R6 busy clears after last word", int'(busy), 0);
        check(ready_cnt == 3, "R5 handoff count", ready_cnt, 3);

        xfer(8'hC3, 8'h5A, 1'b0, 8'h00, "R8 repeat last byte");
        check(ready_cnt == 3, "R5 no pulse on repeat", ready_cnt, 3);
        bus_read(b);
        check(b == 8'hC3, "R9 latest data read", int'(b), 8'hC3);
        @(negedge clk);
        check(rx_valid == 0 && overrun == 0, "R10 read clears flags", int'(overrun), 0);

        repeat (4) @(negedge clk);
        check(rx_q.size() == 0, "R4 all words seen", rx_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule